// File: doc/BRIEF.md
# Edge-to-Edge Time Interval Meter

This block measures how many system clock cycles separate an edge on one input line (the start line) from a later edge on a second line (the stop line). Both lines are asynchronous to the clock. They are brought into the clock domain by a two-flop synchronizer, and each line has its own edge selector that picks rising edges, falling edges or both. The meter arms on a qualifying start edge and then counts until a qualifying stop edge. It publishes the count and raises a ready flag. It then returns to waiting for a fresh start edge, so each published word is a new and independent measurement.

The result word carries two special cases in bit 31. If the count reaches the configured limit before a stop edge arrives, the word is exactly 0x8000_0000 (a timeout). If a new word is published while ready is still high, the meter lost a measurement: bit 31 is set and stays set until the next acknowledge, and bits 30:0 hold the newest interval. A consumer pulses the acknowledge input to clear ready. Lowering the enable input returns the whole meter to its idle, cleared state. When a stop edge ends a measurement, a polarity output records whether that edge was rising or falling, which matters in the both-edges mode.

Top module: `interval_meter`

## Requirements
- R1: While `en` is low (and after `rst_n`), `result` is 0, `ready` is 0 and `stop_rise` is 0, and the meter waits for a start edge once `en` returns high.
- R2: A start edge accepted in one cycle and a stop edge accepted N cycles later publish `result` = N (bit 31 clear) with `ready` = 1. Both lines have the same synchronizer latency, so N equals the spacing of the two input changes.
- R3: Stop edges that arrive while the meter waits for a start edge do not publish anything and do not start a count.
- R4: Start edges that arrive while the meter waits for a stop edge neither restart nor end the count.
- R5: When a start edge and a stop edge occur in the same cycle, the start edge arms the meter and the coincident stop edge is not taken. The result comes from the next qualifying stop edge.
- R6: Edge select codes apply per line: 2'b00 selects rising edges only, 2'b01 falling edges only, 2'b10 and 2'b11 both edges. Edges of the unselected polarity are ignored.
- R7: On every stop-ended measurement, `stop_rise` is 1 if the ending stop edge was rising and 0 if it was falling.
- R8: If TIMEOUT cycles pass after arming without a stop edge, `result` becomes exactly 0x8000_0000, `ready` rises and the meter re-arms for a start edge.
- R9: A publish while `ready` is still high and `ack` is low sets bit 31 of `result` with bits 30:0 holding the newest interval. An `ack` clears that flag, so the next publish is clean.
- R10: A one-cycle `ack` with no publish in that cycle clears `ready` on the next edge and leaves `result` unchanged.
- R11: After a publish, further stop edges without a new start edge publish nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, the unit of measurement |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Enable; low clears and holds the meter idle |
| start_sel | input | 2 | Edge select for the start line |
| stop_sel | input | 2 | Edge select for the stop line |
| start_in | input | 1 | Asynchronous start line |
| stop_in | input | 1 | Asynchronous stop line |
| ack | input | 1 | Clears ready and the lost-measurement flag |
| result | output | 32 | Interval, timeout word or lost-flagged interval |
| ready | output | 1 | A result is waiting to be acknowledged |
| stop_rise | output | 1 | Polarity of the stop edge that ended the last measurement |

## Verification
The assertions assume that `en`, `ack` and the edge selects are synchronous to the clock. They also assume the edge selects change only while `en` is low, so a polarity check never straddles a select change. The bench drives every input just after the falling clock edge and changes the selects only with the meter disabled. It keeps pulses on the asynchronous lines at least one cycle wide, so no edge is lost in the synchronizer and the expected interval stays exactly the spacing of the driven changes.

// File: rtl/im_pkg.sv
package im_pkg;

  localparam int RES_W = 32;
  localparam int CNT_W = RES_W - 1;

  typedef enum logic [1:0] {
    SEL_RISE  = 2'b00,
    SEL_FALL  = 2'b01,
    SEL_BOTH  = 2'b10,
    SEL_BOTH2 = 2'b11
  } edge_sel_e;

  typedef enum logic {
    ST_WAIT_START = 1'b0,
    ST_WAIT_STOP  = 1'b1
  } arm_state_e;

  // Does the transition prev->cur qualify under the selected polarity?
  function automatic logic edge_hit(input logic [1:0] sel, input logic prev, input logic cur);
    logic rise, fall;
    rise = cur & ~prev;
    fall = prev & ~cur;
    case (sel)
      SEL_RISE: edge_hit = rise;
      SEL_FALL: edge_hit = fall;
      default:  edge_hit = rise | fall;
    endcase
  endfunction

  // Saturating increment toward a limit.
  function automatic logic [CNT_W-1:0] sat_inc(input logic [CNT_W-1:0] cnt,
                                               input logic [CNT_W-1:0] lim);
    sat_inc = (cnt >= lim) ? lim : cnt + 1'b1;
  endfunction

  // Build the published word: bit 31 flags timeout or loss.
  function automatic logic [RES_W-1:0] pack_result(input logic timed_out, input logic lost,
                                                   input logic [CNT_W-1:0] interval);
    pack_result = {timed_out | lost, timed_out ? {CNT_W{1'b0}} : interval};
  endfunction

endpackage

// File: rtl/im_edge_chan.sv
module im_edge_chan
  import im_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       din,
  input  logic [1:0] sel,
  output logic       hit,
  output logic       rose
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   cur;

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[0] <= 1'b0;
          else        sync_q[0] <= din;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (!rst_n) sync_q[s] <= 1'b0;
          else        sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  assign cur = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cur;
  end

  assign hit  = edge_hit(sel, prev_q, cur);
  assign rose = cur & ~prev_q;

  AST_HIT_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cur != prev_q)); // R6

endmodule

// File: rtl/im_core.sv
module im_core
  import im_pkg::*;
#(
  parameter logic [CNT_W-1:0] TIMEOUT = 31'h7FFF_FFFF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             start_hit,
  input  logic             stop_hit,
  input  logic             stop_rose,
  input  logic             ack,
  output logic [RES_W-1:0] result,
  output logic             ready,
  output logic             stop_rise
);

  arm_state_e       st_q;
  logic [CNT_W-1:0] cnt_q;
  logic [RES_W-1:0] result_q;
  logic             ready_q;
  logic             miss_q;
  logic             pol_q;

  // Named internal events
  logic accept_start;
  logic finish_stop;
  logic hit_limit;
  logic publish;
  logic lost;

  assign accept_start = (st_q == ST_WAIT_START) && start_hit;
  assign finish_stop  = (st_q == ST_WAIT_STOP) && stop_hit;
  assign hit_limit    = (st_q == ST_WAIT_STOP) && !stop_hit && (cnt_q >= TIMEOUT);
  assign publish      = finish_stop || hit_limit;
  assign lost         = (ready_q || miss_q) && !ack;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st_q     <= ST_WAIT_START;
      cnt_q    <= '0;
      result_q <= '0;
      ready_q  <= 1'b0;
      miss_q   <= 1'b0;
      pol_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_WAIT_START: begin
          if (accept_start) begin
            st_q  <= ST_WAIT_STOP;
            cnt_q <= {{(CNT_W-1){1'b0}}, 1'b1};
          end
        end
        default: begin
          if (publish) begin
            st_q  <= ST_WAIT_START;
            cnt_q <= '0;
          end else begin
            cnt_q <= sat_inc(cnt_q, TIMEOUT);
          end
        end
      endcase

      if (publish) begin
        result_q <= pack_result(hit_limit, lost, cnt_q);
        ready_q  <= 1'b1;
        miss_q   <= lost;
        if (finish_stop) pol_q <= stop_rose;
      end else if (ack) begin
        ready_q <= 1'b0;
        miss_q  <= 1'b0;
      end
    end
  end

  assign result    = result_q;
  assign ready     = ready_q;
  assign stop_rise = pol_q;

  AST_EN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (result_q == '0 && !ready_q && !pol_q)); // R1
  AST_INTERVAL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_q && !result_q[RES_W-1]) |-> (result_q[CNT_W-1:0] != '0 && result_q[CNT_W-1:0] <= TIMEOUT)); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && st_q == ST_WAIT_START) |=> (!en || $stable(result_q))); // R3
  AST_TIMEOUT_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && hit_limit) |=> (!en || (result_q[RES_W-1] && result_q[CNT_W-1:0] == '0))); // R8
  AST_LOSS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (en && publish && ready_q && !ack) |=> (!en || result_q[RES_W-1])); // R9
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (en && ack && !publish) |=> (!ready_q && (!en || $stable(result_q)))); // R10
  AST_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (en && publish) |=> (!en || st_q == ST_WAIT_START)); // R11

endmodule

// File: rtl/interval_meter.sv
module interval_meter
  import im_pkg::*;
#(
  parameter int               SYNC_STAGES = 2,
  parameter logic [CNT_W-1:0] TIMEOUT     = 31'h7FFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [1:0]  start_sel,
  input  logic [1:0]  stop_sel,
  input  logic        start_in,
  input  logic        stop_in,
  input  logic        ack,
  output logic [31:0] result,
  output logic        ready,
  output logic        stop_rise
);

  logic start_hit, start_rose;
  logic stop_hit, stop_rose;

  im_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) start_chan_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (start_in),
    .sel  (start_sel),
    .hit  (start_hit),
    .rose (start_rose)
  );

  im_edge_chan #(.SYNC_STAGES(SYNC_STAGES)) stop_chan_i (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (stop_in),
    .sel  (stop_sel),
    .hit  (stop_hit),
    .rose (stop_rose)
  );

  im_core #(.TIMEOUT(TIMEOUT)) core_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .stop_rose (stop_rose),
    .ack       (ack),
    .result    (result),
    .ready     (ready),
    .stop_rise (stop_rise)
  );

  AST_START_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (start_hit && start_sel == SEL_RISE) |-> start_rose); // R6
  AST_STOP_POLARITY: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_hit && stop_sel == SEL_FALL) |-> !stop_rose); // R6

endmodule

// File: tb/interval_meter_tb_top.sv
module interval_meter_tb_top;

  localparam int TMO = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [1:0]  start_sel = 2'b10;
  logic [1:0]  stop_sel = 2'b10;
  logic        start_in = 1'b0;
  logic        stop_in = 1'b0;
  logic        ack = 1'b0;
  logic [31:0] result;
  logic        ready;
  logic        stop_rise;

  int checks = 0;
  int failures = 0;
  bit auto_mode = 1'b0;
  logic [32:0] exp_q[$];

  always #2 clk = ~clk;

  interval_meter #(.TIMEOUT(31'(TMO))) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .start_sel(start_sel), .stop_sel(stop_sel),
    .start_in(start_in), .stop_in(stop_in), .ack(ack),
    .result(result), .ready(ready), .stop_rise(stop_rise)
  );

  task automatic chk(input bit ok, input string tag, input logic [32:0] act, input logic [32:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: one scoreboarded measurement of n cycles, both selects on both edges.
  task automatic measure(input int n, input string tag);
    logic pol;
    pol = ~stop_in;
    exp_q.push_back({pol, 32'(n)});
    start_in = ~start_in;
    tick(n);
    stop_in = ~stop_in;
    while (exp_q.size() != 0) tick(1);
    tick(2);
    checks++;
    if (ready !== 1'b0) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x0 (ready after ack)", tag, ready);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // Monitor: pops an expected item whenever a result appears, then acknowledges it.
  initial begin
    forever begin
      @(negedge clk);
      if (auto_mode && ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R11 unexpected publish", {stop_rise, result}, 33'h0);
        end else begin
          logic [32:0] e;
          e = exp_q.pop_front();
          chk({stop_rise, result} === e, "R2/R7 scoreboard", {stop_rise, result}, e);
        end
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 33'h0, 33'h1);
    finish_run();
  end

  initial begin
    tick(3);
    chk(result === 32'h0 && ready === 1'b0 && stop_rise === 1'b0, "R1 reset state",
        {ready, result}, 33'h0);
    rst_n = 1'b1;
    en = 1'b1;
    tick(3);
    auto_mode = 1'b1;

    // R2: several spacings
    measure(1, "R2 n=1");
    measure(5, "R2 n=5");
    measure(17, "R2 n=17");
    measure(TMO, "R2 n=limit");

    // R3: lone stop edge while waiting for start
    auto_mode = 1'b0;
    stop_in = ~stop_in;
    tick(8);
    chk(ready === 1'b0, "R3 stop ignored", {32'h0, ready}, 33'h0);
    auto_mode = 1'b1;
    measure(6, "R3 follow-up");

    // R4: extra start edges while counting
    begin
      exp_q.push_back({~stop_in, 32'd12});
      start_in = ~start_in;
      tick(3);
      start_in = ~start_in;
      tick(4);
      start_in = ~start_in;
      tick(5);
      stop_in = ~stop_in;
      while (exp_q.size() != 0) tick(1);
      tick(2);
      chk(1'b1, "R4 restart ignored", 33'h0, 33'h0);
    end

    // R5: coincident start and stop edges
    begin
      start_in = ~start_in;
      stop_in = ~stop_in;
      tick(9);
      exp_q.push_back({~stop_in, 32'd9});
      stop_in = ~stop_in;
      while (exp_q.size() != 0) tick(1);
      tick(2);
      chk(1'b1, "R5 coincident", 33'h0, 33'h0);
    end

    // R11: stop edge after a publish, no new start
    auto_mode = 1'b0;
    stop_in = ~stop_in;
    tick(8);
    chk(ready === 1'b0, "R11 no rearm without start", {32'h0, ready}, 33'h0);

    // R8: timeout word, then re-arm
    start_in = ~start_in;
    tick(60);
    chk(ready === 1'b0, "R8 before limit", {32'h0, ready}, 33'h0);
    tick(10);
    chk(ready === 1'b1 && result === 32'h8000_0000, "R8 timeout word",
        {ready, result}, {1'b1, 32'h8000_0000});
    // R10: ack clears ready, keeps result
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(1);
    chk(ready === 1'b0 && result === 32'h8000_0000, "R10 ack clears ready",
        {ready, result}, {1'b0, 32'h8000_0000});
    auto_mode = 1'b1;
    measure(4, "R8 re-armed");

    // R9: lost measurement
    auto_mode = 1'b0;
    start_in = ~start_in;
    tick(5);
    stop_in = ~stop_in;
    tick(6);
    chk(ready === 1'b1 && result === 32'd5, "R9 first result", {ready, result}, {1'b1, 32'd5});
    start_in = ~start_in;
    tick(9);
    stop_in = ~stop_in;
    tick(6);
    chk(ready === 1'b1 && result === 32'h8000_0009, "R9 loss flagged",
        {ready, result}, {1'b1, 32'h8000_0009});
    ack = 1'b1;
    tick(1);
    ack = 1'b0;
    tick(1);
    chk(ready === 1'b0, "R9 ack clears", {32'h0, ready}, 33'h0);
    auto_mode = 1'b1;
    measure(7, "R9 clean after ack");

    // R1: enable low mid-measurement
    auto_mode = 1'b0;
    start_in = ~start_in;
    tick(5);
    en = 1'b0;
    tick(3);
    chk(result === 32'h0 && ready === 1'b0 && stop_rise === 1'b0, "R1 enable clears",
        {ready, result}, 33'h0);

    // R6/R7: start on rising only, stop on falling only
    start_in = 1'b1;
    stop_in = 1'b1;
    start_sel = 2'b00;
    stop_sel = 2'b01;
    tick(4);
    en = 1'b1;
    tick(3);
    start_in = 1'b0;
    tick(4);
    stop_in = 1'b0;
    tick(6);
    chk(ready === 1'b0, "R6 wrong polarity ignored", {32'h0, ready}, 33'h0);
    auto_mode = 1'b1;
    exp_q.push_back({1'b0, 32'd8});
    start_in = 1'b1;
    tick(3);
    stop_in = 1'b1;
    tick(5);
    stop_in = 1'b0;
    while (exp_q.size() != 0) tick(1);
    tick(2);
    chk(1'b1, "R6 select honoured", 33'h0, 33'h0);

    // R7: rising stop edge reported under both-edge select
    en = 1'b0;
    tick(2);
    start_sel = 2'b11;
    stop_sel = 2'b10;
    en = 1'b1;
    tick(3);
    measure(3, "R7 rising stop");
    measure(3, "R7 falling stop");

    finish_run();
  end

endmodule